// File: doc/BRIEF.md
# Time-Sliced Memory Phase Arbiter

This block hands out the main-memory grant to a set of cores using a fixed round of time slots, one slot per core. Software on each core runs as a chain of intervals: a memory phase that loads the data it needs, then a computation phase that works from local storage. A core raises its request line for the length of a memory phase. The arbiter lets that phase begin only while the core's own slot is open. Once a phase has begun, the arbiter does not take the grant away until the core reports that the phase is finished.

Each core also receives a slot-open indication. The core can use it to move a pending memory phase ahead of its computation work while its window lasts. If a phase is still running when its slot ends, the round pauses: no slot is open until the phase finishes. The following slot then starts late but keeps its full length. Every such pause increments a saturating counter.

The share of memory time given to each core is its slot length divided by the nominal period, which is the sum of all slot lengths. This share is reported as a fixed-point fraction with 8 fraction bits. The slot lengths and the core count (2 to 8) are parameters. Every slot must be at least 2 cycles long.

Top module: `tdma_mem_arb`

## Requirements
- R1: After reset the slots open in ascending core order starting at core 0, wrapping after the last core. Each slot keeps its `slotActive` bit high for exactly its configured number of cycles. With the defaults, core 0 has 4 cycles and core 1 has 6, so the period is 10.
- R2: A grant to core c starts one cycle after a clock edge at which `slotActive[c]`, `memReq[c]` and no held grant are all seen, provided that edge is not the slot's last cycle. A request first seen in the last cycle of the slot, or outside the slot, waits for the core's next slot.
- R3: A granted phase keeps `memGrant[c]` high until `phaseDone[c]` is sampled high while the grant is held. The grant falls in the following cycle.
- R4: If a phase still holds the grant when its slot ends, all `slotActive` bits stay low until the cycle after `phaseDone`. The next core's slot then opens with its full length. A phase that completes in the slot's last cycle causes no such delay.
- R5: `overrunCount` increments by exactly one for each delayed slot change and saturates at all ones.
- R6: At most one bit of `memGrant` is high in any cycle.
- R7: The following have no effect on grants, slots or the counter: a `phaseDone` pulse from a core that holds no grant, and a request from a core whose slot is not open.
- R8: When a phase ends inside its own slot while the core keeps its request high, a new phase is granted two cycles after the `phaseDone` cycle, if the slot is still open before its last cycle.
- R9: `bwShare` field c (9 bits, core 0 in the lowest bits) equals floor(slotLen[c]*256/period). With the defaults the fields are 102 and 153.
- R10: During reset all grants are low, only `slotActive[0]` is high, and `overrunCount` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | input | NUM_CORES | Per-core memory-phase request, held for the phase |
| phaseDone | input | NUM_CORES | Per-core pulse marking the end of the granted phase |
| slotActive | output | NUM_CORES | One-hot open-slot indication, all low during an overrun |
| memGrant | output | NUM_CORES | Per-core memory grant, at most one high |
| overrunCount | output | OVR_W | Saturating count of delayed slot changes |
| bwShare | output | NUM_CORES*9 | Per-core bandwidth share, 8 fraction bits |

## Verification
Some properties are checked by assertions on every cycle. These are: a single grant holder, a grant rising only while its owner's slot is open, a grant that holds until phase completion and drops right after it, slots that are closed only while a phase is being held, a slot counter that stays within its length, and a counter that moves by at most one per cycle. Other behaviours are shown only by the bench scenarios. These include the exact grant latency for each request position across a whole period for both cores, the no-start rule for the last cycle of a slot, the late but full-length slot after an overrun, back-to-back phases in one slot, the saturation point of the counter, and the share values.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;

  localparam int unsigned MAX_CORES    = 8;
  localparam int unsigned SLOT_LEN_W   = 8;
  localparam int unsigned SHARE_FRAC_W = 8;

  // Strobes from the slot sequencer to the grant datapath
  typedef struct packed {
    logic startOpen;     // slot open and not in its final cycle
    logic enterOverrun;  // slot ended while a phase is still held
  } ctrlStrobe_t;

  function automatic int unsigned slotLenOf(
    input logic [MAX_CORES*SLOT_LEN_W-1:0] lens,
    input int unsigned idx
  );
    return 32'(lens[idx*SLOT_LEN_W +: SLOT_LEN_W]);
  endfunction

  function automatic int unsigned periodOf(
    input logic [MAX_CORES*SLOT_LEN_W-1:0] lens,
    input int unsigned numCores
  );
    int unsigned total;
    total = 0;
    for (int unsigned i = 0; i < numCores; i++) begin
      total += slotLenOf(lens, i);
    end
    return total;
  endfunction

endpackage

// File: rtl/tdma_arb_ctrl.sv
module tdma_arb_ctrl
  import tdma_arb_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter logic [MAX_CORES*SLOT_LEN_W-1:0] SLOT_LENS = 64'h0404040404040604,
  localparam int unsigned IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busy,
  input  logic                 doneNow,
  output logic [IDX_W-1:0]     curSlot,
  output logic [NUM_CORES-1:0] slotActive,
  output ctrlStrobe_t          strobe
);

  typedef enum logic {ST_RUN, ST_OVERRUN} seqState_t;

  seqState_t             state;
  logic [SLOT_LEN_W-1:0] slotCnt;
  logic [SLOT_LEN_W-1:0] curLen;
  logic [SLOT_LEN_W-1:0] lenTable [NUM_CORES];
  logic [IDX_W-1:0]      nextSlot;
  logic                  lastCycle;

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : gLen
      assign lenTable[g] = SLOT_LENS[g*SLOT_LEN_W +: SLOT_LEN_W];
    end
  endgenerate

  assign curLen    = lenTable[curSlot];
  assign nextSlot  = (curSlot == IDX_W'(NUM_CORES-1)) ? '0 : curSlot + 1'b1;
  assign lastCycle = (state == ST_RUN) && (slotCnt == curLen - 1'b1);

  assign strobe.startOpen    = (state == ST_RUN) && !lastCycle;
  assign strobe.enterOverrun = lastCycle && busy && !doneNow;

  always_comb begin
    slotActive = '0;
    if (state == ST_RUN) slotActive[curSlot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      curSlot <= '0;
      slotCnt <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (lastCycle) begin
            if (busy && !doneNow) begin
              state <= ST_OVERRUN;
            end else begin
              curSlot <= nextSlot;
              slotCnt <= '0;
            end
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
        ST_OVERRUN: begin
          if (doneNow) begin
            state   <= ST_RUN;
            curSlot <= nextSlot;
            slotCnt <= '0;
          end
        end
      endcase
    end
  end

  // R1: the position inside an open slot never reaches the slot length
  assert_slot_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (slotCnt < curLen));

  // R4: the round is only held while some phase keeps the grant
  assert_overrun_needs_holder_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OVERRUN) |-> busy);

endmodule

// File: rtl/tdma_arb_dp.sv
module tdma_arb_dp
  import tdma_arb_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter logic [MAX_CORES*SLOT_LEN_W-1:0] SLOT_LENS = 64'h0404040404040604,
  parameter int unsigned OVR_W = 8,
  localparam int unsigned IDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned SHARE_W = SHARE_FRAC_W + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CORES-1:0]         memReq,
  input  logic [NUM_CORES-1:0]         phaseDone,
  input  logic [IDX_W-1:0]             curSlot,
  input  ctrlStrobe_t                  strobe,
  output logic [NUM_CORES-1:0]         memGrant,
  output logic                         busy,
  output logic                         doneNow,
  output logic [OVR_W-1:0]             overrunCount,
  output logic [NUM_CORES*SHARE_W-1:0] bwShare
);

  localparam int unsigned PERIOD = periodOf(SLOT_LENS, NUM_CORES);

  logic [NUM_CORES-1:0] grantReg;
  logic [NUM_CORES-1:0] ownerMask;
  logic                 ownerReq;

  assign busy      = |grantReg;
  assign doneNow   = |(grantReg & phaseDone);
  assign ownerMask = {{(NUM_CORES-1){1'b0}}, 1'b1} << curSlot;
  assign ownerReq  = memReq[curSlot];
  assign memGrant  = grantReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantReg <= '0;
    end else if (busy && doneNow) begin
      grantReg <= '0;
    end else if (!busy && strobe.startOpen && ownerReq) begin
      grantReg <= ownerMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrunCount <= '0;
    end else if (strobe.enterOverrun && (overrunCount != '1)) begin
      overrunCount <= overrunCount + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : gShare
      localparam int unsigned SHARE_VAL =
        (slotLenOf(SLOT_LENS, g) * (1 << SHARE_FRAC_W)) / PERIOD;
      assign bwShare[g*SHARE_W +: SHARE_W] = SHARE_W'(SHARE_VAL);

      // R3: a started phase is never taken away before completion
      assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rstN)
        (grantReg[g] && !phaseDone[g]) |=> grantReg[g]);

      // R3: completion releases the grant in the next cycle
      assert_grant_release_R3: assert property (@(posedge clk) disable iff (!rstN)
        (grantReg[g] && phaseDone[g]) |=> !grantReg[g]);
    end
  endgenerate

  // R6: single holder
  assert_single_holder_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantReg));

  // R5: the counter only ever steps by one
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCount != $past(overrunCount)) |-> (overrunCount == $past(overrunCount) + 1'b1));

endmodule

// File: rtl/tdma_mem_arb.sv
module tdma_mem_arb
  import tdma_arb_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter logic [MAX_CORES*SLOT_LEN_W-1:0] SLOT_LENS = 64'h0404040404040604,
  parameter int unsigned OVR_W = 8,
  localparam int unsigned IDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned SHARE_W = SHARE_FRAC_W + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CORES-1:0]         memReq,
  input  logic [NUM_CORES-1:0]         phaseDone,
  output logic [NUM_CORES-1:0]         slotActive,
  output logic [NUM_CORES-1:0]         memGrant,
  output logic [OVR_W-1:0]             overrunCount,
  output logic [NUM_CORES*SHARE_W-1:0] bwShare
);

  logic             busy;
  logic             doneNow;
  logic [IDX_W-1:0] curSlot;
  ctrlStrobe_t      strobe;

  tdma_arb_ctrl #(
    .NUM_CORES (NUM_CORES),
    .SLOT_LENS (SLOT_LENS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .doneNow    (doneNow),
    .curSlot    (curSlot),
    .slotActive (slotActive),
    .strobe     (strobe)
  );

  tdma_arb_dp #(
    .NUM_CORES (NUM_CORES),
    .SLOT_LENS (SLOT_LENS),
    .OVR_W     (OVR_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .memReq       (memReq),
    .phaseDone    (phaseDone),
    .curSlot      (curSlot),
    .strobe       (strobe),
    .memGrant     (memGrant),
    .busy         (busy),
    .doneNow      (doneNow),
    .overrunCount (overrunCount),
    .bwShare      (bwShare)
  );

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : gPortChk
      // R2: a grant only starts inside its owner's open slot
      assert_grant_in_slot_R2: assert property (@(posedge clk) disable iff (!rstN)
        $rose(memGrant[g]) |-> slotActive[g]);
    end
  endgenerate

  // R4: all slots closed means a phase is being held past its slot
  assert_closed_round_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotActive == '0) |-> (memGrant != '0));

  // R1: never more than one open slot
  assert_one_slot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotActive));

endmodule

// File: tb/tdma_mem_arb_tb_top.sv
`timescale 1ns/1ps
module tdma_mem_arb_tb_top;

  localparam int P = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  memReq;
  logic [1:0]  phaseDone;
  logic [1:0]  slotActive;
  logic [1:0]  memGrant;
  logic [7:0]  overrunCount;
  logic [17:0] bwShare;

  int cyc;
  int checks;
  int errs;

  always #4 clk = ~clk;

  tdma_mem_arb dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .memReq       (memReq),
    .phaseDone    (phaseDone),
    .slotActive   (slotActive),
    .memGrant     (memGrant),
    .overrunCount (overrunCount),
    .bwShare      (bwShare)
  );

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expSlot(input int pos);
    return (pos < 4) ? 1 : 2;
  endfunction

  function automatic int slotStart(input int c);
    return (c == 0) ? 0 : 4;
  endfunction

  function automatic int slotLen(input int c);
    return (c == 0) ? 4 : 6;
  endfunction

  function automatic int expDelay(input int c, input int p);
    int s;
    int l;
    s = slotStart(c);
    l = slotLen(c);
    if (p >= s && p <= s + l - 2) return 1;
    return ((s - p + P) % P) + 1;
  endfunction

  task automatic waitPos(input int p);
    for (int i = 0; i < P + 1; i++) begin
      if (cyc % P == p) break;
      tick();
    end
  endtask

  task automatic runAll();
    int n;
    rstN = 1'b0;
    memReq = '0;
    phaseDone = '0;
    cyc = 0;
    repeat (3) @(negedge clk);
    checkEq("R10", "grant in reset", int'(memGrant), 0);
    checkEq("R10", "slot in reset", int'(slotActive), 1);
    checkEq("R10", "counter in reset", int'(overrunCount), 0);
    checkEq("R9", "share core0", int'(bwShare[8:0]), (4 * 256) / P);
    checkEq("R9", "share core1", int'(bwShare[17:9]), (6 * 256) / P);
    rstN = 1'b1;
    cyc = 0;

    // R1 rotation, R7 stray completion pulses are ignored
    for (int i = 0; i < 30; i++) begin
      phaseDone = (i % 3 == 0) ? 2'b11 : 2'b00;
      tick();
      checkEq("R1", "idle slot", int'(slotActive), expSlot(cyc % P));
      checkEq("R7", "idle grant", int'(memGrant), 0);
    end
    phaseDone = '0;
    checkEq("R7", "idle counter", int'(overrunCount), 0);

    // R2 latency sweep over every request position for both cores
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < P; p++) begin
        waitPos(p);
        memReq[c] = 1'b1;
        n = 0;
        while (n < 3 * P) begin
          tick();
          n++;
          if (memGrant[c]) break;
        end
        checkEq("R2", $sformatf("delay core%0d pos%0d", c, p), n, expDelay(c, p));
        checkEq("R2", "owner slot open at grant", int'(slotActive[c]), 1);
        checkEq("R6", "only owner granted", int'(memGrant), 1 << c);
        phaseDone[c] = 1'b1;
        memReq[c] = 1'b0;
        tick();
        phaseDone = '0;
        checkEq("R3", "release after done", int'(memGrant), 0);
        checkEq("R4", "no overrun for in-slot finish", int'(overrunCount), 0);
      end
    end

    // R8 back-to-back phases inside one slot
    waitPos(4);
    memReq[1] = 1'b1;
    tick();
    checkEq("R8", "first phase", int'(memGrant), 2);
    phaseDone[1] = 1'b1;
    tick();
    phaseDone = '0;
    checkEq("R8", "gap after done", int'(memGrant), 0);
    tick();
    checkEq("R8", "second phase", int'(memGrant), 2);
    phaseDone[1] = 1'b1;
    memReq[1] = 1'b0;
    tick();
    phaseDone = '0;
    checkEq("R8", "second release", int'(memGrant), 0);

    // R4 overrun of core 0 with core 1 waiting
    waitPos(0);
    memReq = 2'b11;
    tick();
    checkEq("R2", "core0 granted", int'(memGrant), 1);
    tick();
    tick();
    checkEq("R3", "held in slot", int'(memGrant), 1);
    tick();
    checkEq("R4", "slots closed", int'(slotActive), 0);
    checkEq("R3", "held past slot", int'(memGrant), 1);
    checkEq("R5", "first overrun", int'(overrunCount), 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      checkEq("R4", "still closed", int'(slotActive), 0);
      checkEq("R7", "waiting core not granted", int'(memGrant), 1);
    end
    phaseDone = 2'b01;
    memReq[0] = 1'b0;
    tick();
    phaseDone = '0;
    checkEq("R3", "overrun release", int'(memGrant), 0);
    checkEq("R4", "delayed slot opens", int'(slotActive), 2);
    tick();
    checkEq("R2", "core1 granted at slot start", int'(memGrant), 2);
    phaseDone = 2'b10;
    memReq = '0;
    tick();
    phaseDone = '0;
    checkEq("R3", "core1 release", int'(memGrant), 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      checkEq("R4", "delayed slot full length", int'(slotActive), 2);
    end
    tick();
    checkEq("R4", "round resumes", int'(slotActive), 1);
    checkEq("R5", "single overrun counted", int'(overrunCount), 1);

    // R5 saturation
    for (int k = 0; k < 260; k++) begin
      memReq[0] = 1'b1;
      for (int i = 0; i < 40; i++) begin
        tick();
        if (slotActive == 2'b00) break;
      end
      phaseDone[0] = 1'b1;
      memReq[0] = 1'b0;
      tick();
      phaseDone = '0;
      if (k == 9) checkEq("R5", "count after eleven", int'(overrunCount), 11);
    end
    checkEq("R5", "saturated", int'(overrunCount), 255);
  endtask

  initial begin
    checks = 0;
    errs = 0;
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule